// File: doc/BRIEF.md
# Pipeline Interlock and Stall Controller

This block decides, every cycle, whether a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) may advance. It compares the source registers of the instruction in decode with the destinations of the two older instructions in execute and memory. From that comparison it detects read-after-write dependencies. It then freezes fetch and decode and sends a bubble into execute until the operand can be obtained. A build parameter selects one of two datapaths. In one, results are bypassed to the consumer, and only a load feeding its immediate successor needs a one-cycle wait. In the other, operands come from the register file alone, so a producer anywhere in execute or memory forces a wait.

The controller also holds the pipeline for long-latency execute operations. A start pulse loads a down-counter, and decode stays frozen until the result is due. For branches that resolve in execute, a taken indication clears the wrong-path instruction in IF/ID, turns the ID/EX entry into a bubble and lets the program counter load the redirect target. Write-after-read and write-after-write orderings never stall, because all reads happen in decode and all writes happen in write-back.

Top module: `pipe_interlock`

## Requirements
- R1: A synchronous reset clears the long-latency counter. After reset, with no hazard, the outputs are pcWrEn=1, ifIdWrEn=1, ifIdFlush=0, idExBubble=0, even if a long operation was in progress before the reset.
- R2: A source and a destination match only when the source's read enable is 1, the producer's write enable is 1, and the destination number is not 0. Register 0 and producers with write enable 0, such as bubbles, never cause a stall.
- R3: With FWD_EN=1, the only data stall is a match against the execute-stage producer with its load flag set. A matching ALU producer in execute and any producer in memory cause no stall.
- R4: With FWD_EN=0, any match against the execute-stage or memory-stage producer stalls. A consumer directly behind its producer therefore waits 2 cycles, and a consumer one instruction further back waits 1 cycle.
- R5: In a stall cycle the outputs are pcWrEn=0, ifIdWrEn=0, ifIdFlush=0, idExBubble=1. In a cycle with no stall, no flush and no hazard, the outputs are pcWrEn=1, ifIdWrEn=1, ifIdFlush=0, idExBubble=0.
- R6: With LONG_LAT=12, a longStart pulse stalls the pipeline in its own cycle and in the 11 following cycles. The pipeline is released in the 12th cycle after the pulse.
- R7: When exBrTaken=1, the outputs are ifIdFlush=1, idExBubble=1, pcWrEn=1, ifIdWrEn=1. This takes priority over any data stall or long-latency stall in the same cycle.
- R8: When exBrTaken=0 and there is no hazard, the sequential stream continues with no flush and no bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| decSrcA | input | REG_W | First decode-stage source register number |
| decRdA | input | 1 | First source is read |
| decSrcB | input | REG_W | Second decode-stage source register number |
| decRdB | input | 1 | Second source is read |
| exDst | input | REG_W | Destination register of the instruction in execute |
| exWe | input | 1 | Instruction in execute writes its destination |
| exIsLoad | input | 1 | Instruction in execute is a load |
| memDst | input | REG_W | Destination register of the instruction in memory |
| memWe | input | 1 | Instruction in memory writes its destination |
| exBrTaken | input | 1 | Branch in execute resolved taken |
| longStart | input | 1 | Long-latency operation starts in execute this cycle |
| pcWrEn | output | 1 | Program counter write enable |
| ifIdWrEn | output | 1 | IF/ID register write enable |
| ifIdFlush | output | 1 | Clear IF/ID to an empty instruction |
| idExBubble | output | 1 | Zero the control fields entering ID/EX |

## Verification
The hazard and branch results depend only on the current inputs and on the counter. They are therefore due in the same cycle as the stimulus, and the bench drives inputs on the falling edge and samples one nanosecond later, before the next rising edge. The long-latency result is due in the pulse cycle and then once per rising edge. The bench counts those edges and checks the stall in each of the 11 windows that follow and the release in the 12th. The reset check is sampled in the first window after the rising edge on which reset was applied.

// File: rtl/pipe_ilk_pkg.sv
package pipe_ilk_pkg;
  // Match results passed from the compare unit to the control unit
  typedef struct packed {
    logic exHit;      // decode source matches execute-stage producer
    logic exLoadHit;  // ... and that producer is a load
    logic memHit;     // decode source matches memory-stage producer
  } hazHits_t;
endpackage

// File: rtl/pipe_ilk_compare.sv
module pipe_ilk_compare
  import pipe_ilk_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] decSrcA,
  input  logic             decRdA,
  input  logic [REG_W-1:0] decSrcB,
  input  logic             decRdB,
  input  logic [REG_W-1:0] exDst,
  input  logic             exWe,
  input  logic             exIsLoad,
  input  logic [REG_W-1:0] memDst,
  input  logic             memWe,
  output hazHits_t         hits
);
  localparam int NSRC = 2;

  logic [REG_W-1:0] srcNum [NSRC];
  logic [NSRC-1:0]  srcRd;
  logic [NSRC-1:0]  exMatch;
  logic [NSRC-1:0]  memMatch;
  logic             exValid;
  logic             memValid;

  assign srcNum[0] = decSrcA;
  assign srcNum[1] = decSrcB;
  assign srcRd     = {decRdB, decRdA};

  // register 0 is hard-wired and never produces a dependency
  assign exValid  = exWe  && (exDst  != '0);
  assign memValid = memWe && (memDst != '0);

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign exMatch[s]  = srcRd[s] && exValid  && (srcNum[s] == exDst);
    assign memMatch[s] = srcRd[s] && memValid && (srcNum[s] == memDst);
  end

  always_comb begin
    hits.exHit     = |exMatch;
    hits.exLoadHit = (|exMatch) && exIsLoad;
    hits.memHit    = |memMatch;
  end
endmodule

// File: rtl/pipe_ilk_control.sv
module pipe_ilk_control
  import pipe_ilk_pkg::*;
#(
  parameter bit FWD_EN   = 1'b1,
  parameter int LONG_LAT = 12
) (
  input  logic     clk,
  input  logic     rst,
  input  hazHits_t hits,
  input  logic     exBrTaken,
  input  logic     longStart,
  output logic     pcWrEn,
  output logic     ifIdWrEn,
  output logic     ifIdFlush,
  output logic     idExBubble
);
  localparam int CNT_W = (LONG_LAT > 2) ? $clog2(LONG_LAT) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LONG_LAT - 1);

  logic [CNT_W-1:0] remain;
  logic             longBusy;
  logic             dataStall;
  logic             stall;

  always_ff @(posedge clk) begin
    if (rst)             remain <= '0;
    else if (longStart)  remain <= CNT_LOAD;
    else if (remain != 0) remain <= remain - 1'b1;
  end

  assign longBusy = longStart || (remain != '0);

  if (FWD_EN) begin : g_fwd
    assign dataStall = hits.exLoadHit;
  end else begin : g_nofwd
    assign dataStall = hits.exHit || hits.memHit;
  end

  // taken-branch flush outranks every stall source
  assign stall      = !exBrTaken && (longBusy || dataStall);
  assign pcWrEn     = !stall;
  assign ifIdWrEn   = !stall;
  assign ifIdFlush  = exBrTaken;
  assign idExBubble = exBrTaken || stall;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (remain == '0));

  assert_flush_wins_R7: assert property (@(posedge clk) disable iff (rst)
    exBrTaken |-> (ifIdFlush && pcWrEn && ifIdWrEn && idExBubble));

  assert_hold_pair_R5: assert property (@(posedge clk) disable iff (rst)
    !pcWrEn |-> (!ifIdWrEn && idExBubble && !ifIdFlush));

  assert_long_hold_R6: assert property (@(posedge clk) disable iff (rst)
    longStart |=> (!pcWrEn || exBrTaken));

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
    remain <= CNT_LOAD);

  if (FWD_EN) begin : g_chk_fwd
    assert_alu_free_R3: assert property (@(posedge clk) disable iff (rst)
      (!hits.exLoadHit && !longStart && remain == '0) |-> pcWrEn);
  end else begin : g_chk_nofwd
    assert_mem_stall_R4: assert property (@(posedge clk) disable iff (rst)
      (hits.memHit && !exBrTaken) |-> !pcWrEn);
  end
endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock
  import pipe_ilk_pkg::*;
#(
  parameter int REG_W    = 5,
  parameter bit FWD_EN   = 1'b1,
  parameter int LONG_LAT = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] decSrcA,
  input  logic             decRdA,
  input  logic [REG_W-1:0] decSrcB,
  input  logic             decRdB,
  input  logic [REG_W-1:0] exDst,
  input  logic             exWe,
  input  logic             exIsLoad,
  input  logic [REG_W-1:0] memDst,
  input  logic             memWe,
  input  logic             exBrTaken,
  input  logic             longStart,
  output logic             pcWrEn,
  output logic             ifIdWrEn,
  output logic             ifIdFlush,
  output logic             idExBubble
);
  hazHits_t hits;

  pipe_ilk_compare #(.REG_W(REG_W)) cmp_i (
    .decSrcA(decSrcA), .decRdA(decRdA), .decSrcB(decSrcB), .decRdB(decRdB),
    .exDst(exDst), .exWe(exWe), .exIsLoad(exIsLoad),
    .memDst(memDst), .memWe(memWe), .hits(hits)
  );

  pipe_ilk_control #(.FWD_EN(FWD_EN), .LONG_LAT(LONG_LAT)) ctl_i (
    .clk(clk), .rst(rst), .hits(hits), .exBrTaken(exBrTaken),
    .longStart(longStart), .pcWrEn(pcWrEn), .ifIdWrEn(ifIdWrEn),
    .ifIdFlush(ifIdFlush), .idExBubble(idExBubble)
  );
endmodule

// File: tb/pipe_interlock_tb.sv
`timescale 1ns/1ps
module pipe_interlock_tb_top;
  localparam int RW = 5;
  localparam logic [3:0] FREE  = 4'b1100;  // {pcWrEn, ifIdWrEn, ifIdFlush, idExBubble}
  localparam logic [3:0] STALL = 4'b0001;
  localparam logic [3:0] FLUSH = 4'b1111;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [RW-1:0] decSrcA = '0, decSrcB = '0, exDst = '0, memDst = '0;
  logic decRdA = 0, decRdB = 0, exWe = 0, exIsLoad = 0, memWe = 0;
  logic exBrTaken = 0, longStart = 0;
  logic pcF, ifF, flF, buF, pcN, ifN, flN, buN;
  int   errors = 0;
  int   checks = 0;
  bit   done = 0;

  always #2 clk = ~clk;

  pipe_interlock #(.REG_W(RW), .FWD_EN(1'b1), .LONG_LAT(12)) dut_i (
    .clk(clk), .rst(rst), .decSrcA(decSrcA), .decRdA(decRdA),
    .decSrcB(decSrcB), .decRdB(decRdB), .exDst(exDst), .exWe(exWe),
    .exIsLoad(exIsLoad), .memDst(memDst), .memWe(memWe),
    .exBrTaken(exBrTaken), .longStart(longStart), .pcWrEn(pcF),
    .ifIdWrEn(ifF), .ifIdFlush(flF), .idExBubble(buF));

  pipe_interlock #(.REG_W(RW), .FWD_EN(1'b0), .LONG_LAT(12)) dut_nf_i (
    .clk(clk), .rst(rst), .decSrcA(decSrcA), .decRdA(decRdA),
    .decSrcB(decSrcB), .decRdB(decRdB), .exDst(exDst), .exWe(exWe),
    .exIsLoad(exIsLoad), .memDst(memDst), .memWe(memWe),
    .exBrTaken(exBrTaken), .longStart(longStart), .pcWrEn(pcN),
    .ifIdWrEn(ifN), .ifIdFlush(flN), .idExBubble(buN));

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic chkBoth(input string tag, input logic [3:0] expF, input logic [3:0] expN);
    chk({tag, " fwd"},   {pcF, ifF, flF, buF}, expF);
    chk({tag, " nofwd"}, {pcN, ifN, flN, buN}, expN);
  endtask

  task automatic clearIn();
    decSrcA = '0; decSrcB = '0; exDst = '0; memDst = '0;
    decRdA = 0; decRdB = 0; exWe = 0; exIsLoad = 0; memWe = 0;
    exBrTaken = 0; longStart = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 0;
    #1 chkBoth("R1 reset idle", FREE, FREE);

    // R2 R3 R4 R5 R8: sweep of sources, destinations and flags
    for (int i = 0; i < 8192; i++) begin
      logic hitE, hitM;
      @(negedge clk);
      decSrcA  = RW'(i[1:0]);
      decSrcB  = RW'(i[3:2]);
      decRdA   = i[4];
      decRdB   = i[5];
      exDst    = RW'(i[7:6]);
      exWe     = i[8];
      exIsLoad = i[9];
      memDst   = RW'(i[11:10]);
      memWe    = i[12];
      #1;
      hitE = exWe && exDst != 0 &&
             ((decRdA && decSrcA == exDst) || (decRdB && decSrcB == exDst));
      hitM = memWe && memDst != 0 &&
             ((decRdA && decSrcA == memDst) || (decRdB && decSrcB == memDst));
      chk("R3 R2 R5 sweep", {pcF, ifF, flF, buF}, (hitE && exIsLoad) ? STALL : FREE);
      chk("R4 R2 R8 sweep", {pcN, ifN, flN, buN}, (hitE || hitM) ? STALL : FREE);
    end

    // R4: adjacent dependency walks through EX then MEM -> 2 stall cycles
    @(negedge clk); clearIn();
    decSrcA = 5'd7; decRdA = 1; exDst = 5'd7; exWe = 1;
    #1 chkBoth("R4 adjacent c1", FREE, STALL);
    @(negedge clk); exWe = 0; exDst = '0; memDst = 5'd7; memWe = 1;
    #1 chkBoth("R4 adjacent c2", FREE, STALL);
    @(negedge clk); memWe = 0; memDst = '0;
    #1 chkBoth("R4 adjacent release", FREE, FREE);

    // R6: long-latency hold
    @(negedge clk); clearIn(); longStart = 1;
    #1 chkBoth("R6 long start", STALL, STALL);
    for (int k = 0; k < 11; k++) begin
      @(negedge clk); longStart = 0;
      #1 chkBoth("R6 long hold", STALL, STALL);
    end
    @(negedge clk);
    #1 chkBoth("R6 long release", FREE, FREE);

    // R7: flush wins over load-use and long stalls
    @(negedge clk);
    decSrcB = 5'd3; decRdB = 1; exDst = 5'd3; exWe = 1; exIsLoad = 1;
    memDst = 5'd3; memWe = 1; exBrTaken = 1;
    #1 chkBoth("R7 flush over data", FLUSH, FLUSH);
    @(negedge clk); clearIn(); longStart = 1;
    @(negedge clk); longStart = 0; exBrTaken = 1;
    #1 chkBoth("R7 flush over long", FLUSH, FLUSH);
    @(negedge clk); exBrTaken = 0;
    #1 chkBoth("R6 hold after flush", STALL, STALL);

    // R1: reset clears an active long operation
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    #1 chkBoth("R1 counter cleared", FREE, FREE);

    // R8: not-taken with no hazard continues sequentially
    @(negedge clk); clearIn(); decSrcA = 5'd9; decRdA = 1; exDst = 5'd9; exWe = 0;
    #1 chkBoth("R8 R2 bubble producer", FREE, FREE);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule